// File: doc/BRIEF.md
# Redundant Reference Clock Switchover Controller

This block watches two reference clocks from the feedback clock domain of a downstream PLL. Each reference is sampled through a two-flop synchronizer and checked for rising edges. A reference that stops toggling raises its own sticky fault flag. The block also decides which of the two references feeds the PLL input multiplexer.

In automatic mode the decision is latched. It moves to the healthy reference only when the active reference fails and the other one is still good. In manual mode the select input alone drives the decision. An active-low alarm reset clears both fault flags and realigns the selection with the select input. This reset is turned into a single pulse on its falling edge. The multiplexer select follows the decision register one feedback cycle later, so it changes in one registered step only.

Top module: `clk_switchover`

## Requirements
- R1: `sel_i` low selects reference 0 and high selects reference 1. `clk_sel_o` and `mux_sel_o` use the same encoding: 0 means reference 0 and 1 means reference 1.
- R2: While `rst_ni` is low, `bad_o`, `clk_sel_o` and `mux_sel_o` are all zero, with no clock edge needed.
- R3: `bad_o[j]` (bit 0 for reference 0, bit 1 for reference 1) rises when the synchronized reference j shows no rising edge for `MISS_LIMIT` (default 4) consecutive feedback cycles. A reference toggling every feedback cycle is never flagged.
- R4: A set fault flag stays high, even after its reference recovers, until an alarm pulse occurs.
- R5: A falling edge on `alarm_rst_ni` clears both fault flags and loads `clk_sel_o` with the synchronized `sel_i`. This happens three feedback cycles after the edge is sampled.
- R6: Holding `alarm_rst_ni` low acts only once. A fault that appears while it is held low stays flagged.
- R7: While `man_ovr_i` is high, `clk_sel_o` follows the synchronized `sel_i` and no automatic switch happens.
- R8: In automatic mode, when the active reference is flagged and the other one is not, `clk_sel_o` moves to the other reference and stays there.
- R9: With both references flagged in automatic mode, `clk_sel_o` does not change until an alarm pulse occurs.
- R10: `mux_sel_o` equals `clk_sel_o` delayed by one feedback cycle, so a new selection reaches the multiplexer within two cycles of the decision.
- R11: In automatic mode, a change of `sel_i` alone does not change `clk_sel_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fb_clk_i | input | 1 | Feedback clock. All state runs on this clock. |
| rst_ni | input | 1 | Asynchronous active-low master reset |
| ref_clk_i | input | 2 | Reference clocks, sampled as data (bit j is reference j) |
| sel_i | input | 1 | Preferred reference (0 = ref 0, 1 = ref 1) |
| man_ovr_i | input | 1 | High disables automatic switching |
| alarm_rst_ni | input | 1 | Active-low alarm reset, one-shotted on its falling edge |
| bad_o | output | 2 | Sticky per-reference fault flags |
| clk_sel_o | output | 1 | Reference currently chosen |
| mux_sel_o | output | 1 | Registered select for the reference multiplexer |

## Verification
The assertions check on every cycle:
- that the fault flags are sticky;
- that the alarm pulse lasts a single cycle;
- that the alarm pulse clears the flags and aligns the selection;
- that the selection follows the select input under manual override;
- that the selection is frozen when both references have failed;
- that the multiplexer select lags the decision by exactly one cycle.

Only the bench scenarios can show that a stopped reference is actually detected after the right number of missing edges and that a running one never is. They also show that a held alarm reset acts just once, and that the master reset clears the outputs without a clock edge.

// File: rtl/cso_pkg.sv
package cso_pkg;
  localparam int unsigned NUM_REF = 2;
  typedef logic [NUM_REF-1:0] ref_vec_t;
endpackage

// File: rtl/cso_sync.sv
module cso_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cso_ref_monitor.sv
module cso_ref_monitor #(
  parameter int unsigned MISS_LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_sync_i,
  input  logic clr_i,
  output logic bad_o
);
  localparam int unsigned CNT_W = $clog2(MISS_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MISS_LIMIT - 1);

  logic             ref_q;
  logic             rise;
  logic [CNT_W-1:0] miss_cnt;

  assign rise = ref_sync_i & ~ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q    <= 1'b0;
      miss_cnt <= '0;
      bad_o    <= 1'b0;
    end else begin
      ref_q <= ref_sync_i;
      if (clr_i) begin
        miss_cnt <= '0;
        bad_o    <= 1'b0;
      end else if (rise) begin
        miss_cnt <= '0;
      end else if (miss_cnt == CNT_LAST) begin
        bad_o <= 1'b1;  // counter saturates here
      end else begin
        miss_cnt <= miss_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cso_alarm_oneshot.sv
module cso_alarm_oneshot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic alarm_sync_ni,
  output logic pulse_o
);
  logic alarm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) alarm_q <= 1'b1;
    else         alarm_q <= alarm_sync_ni;
  end

  assign pulse_o = alarm_q & ~alarm_sync_ni;
endmodule

// File: rtl/cso_select_fsm.sv
module cso_select_fsm
  import cso_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sel_i,
  input  logic     ovr_i,
  input  logic     pulse_i,
  input  ref_vec_t bad_i,
  output logic     clk_sel_o,
  output logic     mux_sel_o
);
  logic act_q, act_d;

  always_comb begin
    if (pulse_i || ovr_i)                     act_d = sel_i;
    else if (bad_i[act_q] && !bad_i[~act_q])  act_d = ~act_q;
    else                                      act_d = act_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= 1'b0;
      mux_sel_o <= 1'b0;
    end else begin
      act_q     <= act_d;
      mux_sel_o <= act_q;  // one-cycle lag keeps mux change registered
    end
  end

  assign clk_sel_o = act_q;
endmodule

// File: rtl/clk_switchover.sv
module clk_switchover
  import cso_pkg::*;
#(
  parameter int unsigned MISS_LIMIT  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       fb_clk_i,
  input  logic       rst_ni,
  input  logic [1:0] ref_clk_i,
  input  logic       sel_i,
  input  logic       man_ovr_i,
  input  logic       alarm_rst_ni,
  output logic [1:0] bad_o,
  output logic       clk_sel_o,
  output logic       mux_sel_o
);
  localparam int unsigned SW = NUM_REF + 3;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, 2'b00, {NUM_REF{1'b0}}};

  logic [SW-1:0] sync_q;
  ref_vec_t      ref_sync;
  logic          sel_sync, ovr_sync, alarm_sync_n, alarm_pulse;

  cso_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (fb_clk_i),
    .rst_ni(rst_ni),
    .d_i   ({alarm_rst_ni, man_ovr_i, sel_i, ref_clk_i}),
    .q_o   (sync_q)
  );

  assign ref_sync     = sync_q[NUM_REF-1:0];
  assign sel_sync     = sync_q[NUM_REF];
  assign ovr_sync     = sync_q[NUM_REF+1];
  assign alarm_sync_n = sync_q[NUM_REF+2];

  cso_alarm_oneshot u_oneshot (
    .clk_i        (fb_clk_i),
    .rst_ni       (rst_ni),
    .alarm_sync_ni(alarm_sync_n),
    .pulse_o      (alarm_pulse)
  );

  for (genvar g = 0; g < NUM_REF; g++) begin : g_mon
    cso_ref_monitor #(.MISS_LIMIT(MISS_LIMIT)) u_mon (
      .clk_i     (fb_clk_i),
      .rst_ni    (rst_ni),
      .ref_sync_i(ref_sync[g]),
      .clr_i     (alarm_pulse),
      .bad_o     (bad_o[g])
    );
  end

  cso_select_fsm u_sel (
    .clk_i    (fb_clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_sync),
    .ovr_i    (ovr_sync),
    .pulse_i  (alarm_pulse),
    .bad_i    (bad_o),
    .clk_sel_o(clk_sel_o),
    .mux_sel_o(mux_sel_o)
  );
endmodule

// File: rtl/clk_switchover_chk.sv
module clk_switchover_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       alarm_pulse,
  input logic       sel_sync,
  input logic       ovr_sync,
  input logic [1:0] bad,
  input logic       clk_sel,
  input logic       mux_sel
);
  assert_bad0_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad[0] && !alarm_pulse |=> bad[0]);
  assert_bad1_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad[1] && !alarm_pulse |=> bad[1]);
  assert_pulse_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_pulse |=> !alarm_pulse);
  assert_alarm_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alarm_pulse |=> (bad == 2'b00) && (clk_sel == $past(sel_sync)));
  assert_override_follow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_sync |=> clk_sel == $past(sel_sync));
  assert_both_bad_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&bad) && !alarm_pulse && !ovr_sync |=> $stable(clk_sel));
  assert_mux_lag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> mux_sel == $past(clk_sel));
endmodule

bind clk_switchover clk_switchover_chk u_chk (
  .clk_i      (fb_clk_i),
  .rst_ni     (rst_ni),
  .alarm_pulse(alarm_pulse),
  .sel_sync   (sel_sync),
  .ovr_sync   (ovr_sync),
  .bad        (bad_o),
  .clk_sel    (clk_sel_o),
  .mux_sel    (mux_sel_o)
);

// File: tb/clk_switchover_test.sv
`timescale 1ns/1ps
module clk_switchover_test;
  localparam int LIMIT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ref_clk = 2'b00;
  logic       sel = 1'b0, ovr = 1'b0, alarm_n = 1'b1;
  logic [1:0] bad;
  logic       clk_sel, mux_sel;
  bit         run0 = 1'b0, run1 = 1'b0;

  int    n_chk = 0, n_fail = 0;
  string phase = "R2";

  always #2.5 clk = ~clk;

  clk_switchover #(.MISS_LIMIT(LIMIT)) uut (
    .fb_clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .sel_i(sel),
    .man_ovr_i(ovr), .alarm_rst_ni(alarm_n), .bad_o(bad),
    .clk_sel_o(clk_sel), .mux_sel_o(mux_sel)
  );

  always @(posedge clk) begin
    #1;
    if (run0) ref_clk[0] = ~ref_clk[0];
    if (run1) ref_clk[1] = ~ref_clk[1];
  end

  // behavioural reference model; queues hold inputs seen at past edges
  bit r0q[$], r1q[$], aq[$], sq[$], oq[$];
  int m_miss[2];
  bit m_bad[2];
  bit m_act, m_mux;

  task automatic model_clear();
    r0q = '{0, 0, 0}; r1q = '{0, 0, 0}; aq = '{1, 1, 1};
    sq = '{0, 0, 0};  oq = '{0, 0, 0};
    m_miss = '{0, 0}; m_bad = '{0, 0}; m_act = 0; m_mux = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_clear();
    else begin
      bit pulse, rise, tgt;
      pulse = aq[2] && !aq[1];
      for (int j = 0; j < 2; j++) begin
        rise = (j == 0) ? (r0q[1] && !r0q[2]) : (r1q[1] && !r1q[2]);
        if (pulse) begin m_miss[j] = 0; m_bad[j] = 0; end
        else if (rise) m_miss[j] = 0;
        else if (m_miss[j] >= LIMIT - 1) m_bad[j] = 1;
        else m_miss[j]++;
      end
      if (pulse || oq[1]) tgt = sq[1];
      else if (m_bad_old(m_act) && !m_bad_old(!m_act)) tgt = !m_act;
      else tgt = m_act;
      m_mux = m_act;
      m_act = tgt;
      for (int j = 0; j < 2; j++) bad_prev[j] = m_bad[j];
      r0q.push_front(ref_clk[0]); void'(r0q.pop_back());
      r1q.push_front(ref_clk[1]); void'(r1q.pop_back());
      aq.push_front(alarm_n);     void'(aq.pop_back());
      sq.push_front(sel);         void'(sq.pop_back());
      oq.push_front(ovr);         void'(oq.pop_back());
    end
  end

  // flag values from before the current edge feed the switch decision
  bit bad_prev[2];
  always @(negedge rst_n) bad_prev = '{0, 0};
  function automatic bit m_bad_old(bit idx);
    return bad_prev[idx];
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk)
    check(phase, {bad, clk_sel, mux_sel}, {m_bad[1], m_bad[0], m_act, m_mux});

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1.5;
  endtask

  bit done = 0;
  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #0.5; check("R2", {bad, clk_sel, mux_sel}, 4'b0000);
    step(3); rst_n = 1'b1;
    // R3: both references running, no flags
    phase = "R3"; run0 = 1; run1 = 1;
    step(20);
    check("R3", {2'b00, bad}, 4'b0000);
    // R8/R3: reference 0 stops, switch to reference 1
    phase = "R8"; run0 = 0;
    step(12);
    check("R3", {2'b00, bad}, 4'b0001);
    check("R8", {3'b000, clk_sel}, 4'b0001);
    check("R10", {3'b000, mux_sel}, 4'b0001);
    // R4: reference 0 recovers, flag stays
    phase = "R4"; run0 = 1;
    step(12);
    check("R4", {2'b00, bad}, 4'b0001);
    // R11: select change alone in automatic mode
    phase = "R11"; sel = 1'b0;
    step(8); sel = 1'b1; step(4); sel = 1'b0; step(8);
    check("R11", {3'b000, clk_sel}, 4'b0001);
    // R5/R6: alarm held low, ref 1 then fails
    phase = "R5"; alarm_n = 1'b0;
    step(4);
    check("R5", {bad, clk_sel, 1'b0}, 4'b0000);
    phase = "R6"; run1 = 0;
    step(14);
    check("R6", {2'b00, bad}, 4'b0010);
    check("R6", {3'b000, clk_sel}, 4'b0000);
    alarm_n = 1'b1; step(6);
    // R9: both fail, selection held
    phase = "R9"; run0 = 0;
    step(14);
    check("R9", {bad, clk_sel, 1'b0}, 4'b1100);
    // R1: alarm with select high, both running
    phase = "R1"; run0 = 1; run1 = 1; sel = 1'b1;
    step(4); alarm_n = 1'b0; step(1); alarm_n = 1'b1;
    step(6);
    check("R1", {bad, clk_sel, mux_sel}, 4'b0011);
    // R7: manual override
    phase = "R7"; ovr = 1'b1; sel = 1'b0;
    step(5);
    check("R7", {3'b000, clk_sel}, 4'b0000);
    run0 = 0;
    step(12);
    check("R7", {bad, clk_sel, 1'b0}, 4'b0100);
    sel = 1'b1; step(5);
    check("R7", {3'b000, clk_sel}, 4'b0001);
    // R2: asynchronous master reset between edges
    phase = "R2"; rst_n = 1'b0; #0.5;
    check("R2", {bad, clk_sel, mux_sel}, 4'b0000);
    step(2); rst_n = 1'b1; ovr = 1'b0; run0 = 1;
    step(10);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule